// File: doc/BRIEF.md
# SPI Slave Receive Path with Byte Unstuffing

This block is the receive half of an SPI slave. Its input pins are the serial clock, the serial data in and an active-low select. While the select is held low, the block takes one data bit on each rising serial clock edge. The serial clock idles low. Bits are packed into bytes, most significant bit first. The three pins are brought into the system clock domain through two-flop synchronizers, and the clock edges are found there. The system clock must run at least four times faster than the serial clock.

Each byte that completes goes through an in-band unstuffing stage:

- A filler byte of 0x4A is dropped.
- A marker byte of 0x4D is also dropped, and the byte that follows it is XORed with 0x20.
- Every other byte leaves on a byte-wide stream output. A valid strobe is high for one system clock cycle with each such byte.

When the select rises, the block drops any partial byte and forgets any pending marker. There is no backpressure on the output.

Top module: `spi_rx_unstuff`

## Requirements
- R1: Bits are shifted in only while ss_ni is low. Serial clock edges seen while ss_ni is high shift nothing, advance no bit count and produce no output.
- R2: sdi_i is sampled on each rising edge of sclk_i (sclk_i idles low). The first bit sampled is bit 7 of the byte.
- R3: A received byte equal to 0x4A, arriving with no pending marker, is discarded and gives no valid_o pulse.
- R4: A received byte equal to 0x4D, arriving with no pending marker, is discarded. The next byte received is output XORed with 0x20.
- R5: Each data byte gives exactly one valid_o pulse of one system clock cycle. data_o carries the byte during that cycle.
- R6: A rising ss_ni clears the bit count and any pending marker. Bits of a partial byte are dropped, and the next byte is decoded as if no marker had come before it.
- R7: A byte that follows a marker is always output as data, even when the XOR turns it into 0x4A or 0x4D. Such a byte never acts as a filler or a marker.
- R8: While rst_ni is low, and right after it rises, valid_o is low and data_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master, idles low |
| sdi_i | input | 1 | Serial data from the master |
| ss_ni | input | 1 | Slave select, active low |
| data_o | output | 8 | Decoded byte |
| valid_o | output | 1 | One-cycle strobe marking a decoded byte |

## Verification
A decoded byte shows up on valid_o four system clock edges after the eighth rising serial clock edge reaches the pin:

- two edges for the synchronizer,
- one edge for the shift register and byte strobe,
- one edge for the decoder register.

The bench sends each serial clock phase for five system clocks, so a byte finishes long before the next one starts. The monitor samples on falling system clock edges. It pops the expected byte from the scoreboard queue whenever valid_o is high, and it flags a strobe that lasts two cycles. Each scenario ends with a wait of several clocks, well beyond the four-edge latency, and then a check that the queue is empty. This shows that dropped bytes and ignored edges produced no stray output.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FILL_CODE = 8'h4A;
  localparam logic [BYTE_W-1:0] MARK_CODE = 8'h4D;
  localparam logic [BYTE_W-1:0] FLIP_MASK = 8'h20;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter #(
  parameter int unsigned W = 8,
  localparam int unsigned CNT_W = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_s_i,
  input  logic         sdi_s_i,
  input  logic         ss_s_ni,
  output logic         ss_act_o,
  output logic         byte_v_o,
  output logic [W-1:0] byte_o
);
  logic             sclk_q;
  logic [W-1:0]     sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;
  logic [W-1:0]     sr_nxt;

  assign ss_act_o = ~ss_s_ni;
  assign rise     = sclk_s_i & ~sclk_q;
  assign sr_nxt   = {sr_q[W-2:0], sdi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      sr_q     <= '0;
      cnt_q    <= '0;
      byte_v_o <= 1'b0;
      byte_o   <= '0;
    end else begin
      sclk_q   <= sclk_s_i;
      byte_v_o <= 1'b0;
      if (!ss_act_o) begin
        sr_q  <= '0;
        cnt_q <= '0;
      end else if (rise) begin
        sr_q <= sr_nxt;
        if (cnt_q == CNT_W'(W-1)) begin
          cnt_q    <= '0;
          byte_v_o <= 1'b1;
          byte_o   <= sr_nxt;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_rx_decoder.sv
module spi_rx_decoder
  import spi_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ss_act_i,
  input  logic              byte_v_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              esc_o,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esc_o   <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (byte_v_i) begin
        if (esc_o) begin
          // escaped byte is always data
          esc_o   <= 1'b0;
          valid_o <= 1'b1;
          data_o  <= byte_i ^ FLIP_MASK;
        end else if (byte_i == MARK_CODE) begin
          esc_o <= 1'b1;
        end else if (byte_i != FILL_CODE) begin
          valid_o <= 1'b1;
          data_o  <= byte_i;
        end
      end
      if (!ss_act_i) esc_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_rx_unstuff.sv
module spi_rx_unstuff
  import spi_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              ss_ni,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o
);
  logic [2:0]        pins_s;
  logic              ss_act;
  logic              byte_v;
  logic [BYTE_W-1:0] byte_d;
  logic              esc_q;

  // order: {ss, sdi, sclk}; select resets inactive
  spi_rx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ss_ni, sdi_i, sclk_i}),
    .q_o    (pins_s)
  );

  spi_rx_shifter #(.W(BYTE_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (pins_s[0]),
    .sdi_s_i  (pins_s[1]),
    .ss_s_ni  (pins_s[2]),
    .ss_act_o (ss_act),
    .byte_v_o (byte_v),
    .byte_o   (byte_d)
  );

  spi_rx_decoder u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ss_act_i (ss_act),
    .byte_v_i (byte_v),
    .byte_i   (byte_d),
    .esc_o    (esc_q),
    .valid_o  (valid_o),
    .data_o   (data_o)
  );
endmodule

// File: rtl/spi_rx_unstuff_chk.sv
module spi_rx_unstuff_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_o,
  input logic [7:0] data_o,
  input logic       ss_act,
  input logic       byte_v,
  input logic [7:0] byte_d,
  input logic       esc_q
);
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r3_fill_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_v && !esc_q && byte_d == 8'h4A) |=> !valid_o);

  a_r4_escape_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_v && esc_q) |=> (valid_o && data_o == ($past(byte_d) ^ 8'h20)));

  a_r4_marker_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_v && !esc_q && byte_d == 8'h4D) |=> !valid_o);

  a_r7_escaped_is_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_v && esc_q && (byte_d == 8'h6A || byte_d == 8'h6D)) |=> valid_o);

  a_r6_marker_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_act |=> !esc_q);

  a_r1_no_byte_unselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_act |=> !byte_v);

  always_comb begin
    if (!rst_ni) a_r8_reset_quiet: assert (!valid_o);
  end
endmodule

bind spi_rx_unstuff spi_rx_unstuff_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_o (valid_o),
  .data_o  (data_o),
  .ss_act  (ss_act),
  .byte_v  (byte_v),
  .byte_d  (byte_d),
  .esc_q   (esc_q)
);

// File: tb/sim_spi_rx_unstuff.sv
module sim_spi_rx_unstuff;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF_SCLK  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic       ss_n = 1'b1;
  logic [7:0] data;
  logic       valid;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  logic esc_m = 1'b0;
  logic prev_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rx_unstuff u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .sclk_i  (sclk),
    .sdi_i   (sdi),
    .ss_ni   (ss_n),
    .data_o  (data),
    .valid_o (valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select(input bit on);
    ss_n = ~on;
    if (!on) esc_m = 1'b0;  // R6 model
    clocks(HALF_SCLK * 2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = b[i];
      clocks(HALF_SCLK);
      sclk = 1'b1;
      clocks(HALF_SCLK);
      sclk = 1'b0;
    end
  endtask

  // driver: model decode from R3/R4/R7, push expected output
  task automatic send_byte(input logic [7:0] b);
    if (esc_m) begin
      exp_q.push_back(b ^ 8'h20);
      esc_m = 1'b0;
    end else if (b == 8'h4D) begin
      esc_m = 1'b1;
    end else if (b != 8'h4A) begin
      exp_q.push_back(b);
    end
    send_bits(b, 8);
  endtask

  task automatic drained(input string req);
    clocks(12);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected byte", data, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(data == e, "R2/R4/R5/R7 data", data, e);
        end
        if (prev_valid) chk(1'b0, "R5 pulse width", 2, 1);
      end
      prev_valid <= valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clocks(3);
    chk(valid == 1'b0 && data == 8'h00, "R8 in reset", {valid, data}, 0);
    rst_n = 1'b1;
    clocks(3);
    chk(valid == 1'b0 && data == 8'h00, "R8 after reset", {valid, data}, 0);

    // R2/R5: plain bytes
    select(1);
    send_byte(8'hA5);
    send_byte(8'h00);
    send_byte(8'hFF);
    send_byte(8'h81);
    select(0);
    drained("R2 plain bytes");

    // R3: filler dropped
    select(1);
    send_byte(8'h4A);
    send_byte(8'h12);
    send_byte(8'h4A);
    select(0);
    drained("R3 filler");

    // R4/R7: escapes
    select(1);
    send_byte(8'h4D);
    send_byte(8'h6A);
    send_byte(8'h4D);
    send_byte(8'h6D);
    send_byte(8'h4D);
    send_byte(8'h4D);
    send_byte(8'h4D);
    send_byte(8'h4A);
    send_byte(8'h33);
    select(0);
    drained("R4 R7 escapes");

    // R1: clock edges while unselected
    send_bits(8'hFF, 5);
    drained("R1 unselected edges");
    select(1);
    send_byte(8'h3C);
    select(0);
    drained("R1 count untouched");

    // R6: partial byte dropped
    select(1);
    send_bits(8'hFF, 3);
    select(0);
    select(1);
    send_byte(8'h5A);
    select(0);
    drained("R6 partial dropped");

    // R6: pending marker forgotten
    select(1);
    send_byte(8'h4D);
    select(0);
    select(1);
    send_byte(8'h41);
    select(0);
    drained("R6 marker cleared");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule